// File: doc/BRIEF.md
# Circular-Buffer Address Updater

This block takes an address pointer and works out two things: the address for the current memory access, and the value the pointer will hold afterwards. The pointer can be left alone, stepped up by one, stepped down by one, or moved by a signed 16-bit offset. A modulus input selects either plain two's-complement arithmetic or circular-buffer arithmetic. In circular mode the pointer stays inside a buffer whose size is the modulus value plus one.

No base register is needed. The buffer's lowest address comes from the pointer itself: the pointer's low k bits are cleared, where 2^k is the smallest power of two that can hold the buffer. When the size is not a power of two, the addresses between the buffer's top and the next aligned block cannot be reached by circular updates. The "no update" mode can still address them.

Only the first two pointer selects can use circular arithmetic. The remaining selects always step linearly. Both results appear on registered outputs one clock after the inputs are presented. Instruction decode, the register file and the memory itself are outside this block.

Top module: `mod_addr_unit`

## Requirements
- R1: `ea_out` equals the `ptr_in` value presented one clock earlier, in every update mode.
- R2: Mode code 0 (hold) makes `ptr_out` equal to the earlier `ptr_in`, for any address, including addresses in the unreachable gap.
- R3: Selects 2 and 3 always step linearly, modulo 2^16, whatever the value of `modulus`. Mode 1 adds one, mode 2 subtracts one, and mode 3 adds `offset` read as two's complement.
- R4: A `modulus` of 16'hFFFF makes selects 0 and 1 step linearly as well.
- R5: For selects 0 and 1 with any other `modulus`, the buffer's lowest address is `ptr_in` with its low k bits cleared. Here k is the smallest value for which 2^k >= `modulus`+1.
- R6: In circular mode, adding one at the top address (lowest address + `modulus`) gives the lowest address.
- R7: In circular mode, subtracting one at the lowest address gives the top address.
- R8: In circular mode, an offset move that leaves the buffer is brought back by subtracting or adding the size (`modulus`+1). This holds for |offset| <= size and a pointer that starts inside the buffer.
- R9: With a size of 37 and a lowest address of 16'h0080, no circular update ever produces an address from 16'h00A5 to 16'h00BF.
- R10: While `rst_n` is low, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ptr_in | input | 16 | Current pointer value |
| ptr_sel | input | 2 | Which pointer is in use; 0 and 1 can use circular arithmetic |
| mode | input | 2 | 0 hold, 1 add one, 2 subtract one, 3 add offset |
| offset | input | 16 | Signed step used by mode 3 |
| modulus | input | 16 | Buffer size minus one; all ones selects linear |
| ea_out | output | 16 | Registered access address (pre-update pointer) |
| ptr_out | output | 16 | Registered updated pointer |

## Verification
Two results are produced in the same cycle: the access address and the updated pointer. In the cycle where a circular update wraps, the access address is still the unwrapped pre-update value while the pointer jumps to the other end of the buffer. The bench provokes this case with walks that cross both buffer ends, and with random back-to-back updates that alternate between circular-capable and linear pointer selects while the modulus changes. A behavioural model checks both outputs on every clock, so an access address mixed up with the wrapped result, or a wrap applied to a linear select, shows up on the very cycle it happens.

// File: rtl/mod_addr_pkg.sv
package mod_addr_pkg;

    localparam int AW = 16;

    typedef enum logic [1:0] {
        UPD_HOLD = 2'd0,
        UPD_INC  = 2'd1,
        UPD_DEC  = 2'd2,
        UPD_OFS  = 2'd3
    } upd_mode_e;

    typedef struct packed {
        logic [AW-1:0] ea;
        logic [AW-1:0] ptr;
    } addr_state_t;

endpackage

// File: rtl/mod_mask_gen.sv
// Smears the highest set bit of the modulus downward to form the block mask (2^k - 1).
module mod_mask_gen #(
    parameter int W = 16
) (
    input  logic [W-1:0] modulus,
    output logic [W-1:0] mask
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_smear
            assign mask[i] = |modulus[W-1:i];
        end
    endgenerate
endmodule

// File: rtl/mod_step_gen.sv
// Turns the update mode into a signed step, two bits wider than the address.
module mod_step_gen
    import mod_addr_pkg::*;
#(
    parameter int W = 16
) (
    input  upd_mode_e          mode,
    input  logic [W-1:0]       offset,
    output logic signed [W+1:0] step
);
    always_comb begin
        case (mode)
            UPD_INC: step = (W+2)'(1);
            UPD_DEC: step = -(W+2)'(1);
            UPD_OFS: step = {{2{offset[W-1]}}, offset};
            default: step = '0;
        endcase
    end
endmodule

// File: rtl/mod_wrap_unit.sv
// Adds the step and folds the result back into [base, base+modulus].
module mod_wrap_unit #(
    parameter int W = 16
) (
    input  logic [W-1:0]        ptr,
    input  logic signed [W+1:0] step,
    input  logic [W-1:0]        modulus,
    input  logic [W-1:0]        mask,
    input  logic                circ_en,
    output logic [W-1:0]        next
);
    localparam int XW = W + 2;

    logic signed [XW-1:0] sum_x;
    logic signed [XW-1:0] base_x;
    logic signed [XW-1:0] top_x;
    logic signed [XW-1:0] size_x;
    logic signed [XW-1:0] fold_x;

    always_comb begin
        sum_x  = $signed({2'b00, ptr}) + step;
        base_x = $signed({2'b00, ptr & ~mask});
        top_x  = base_x + $signed({2'b00, modulus});
        size_x = $signed({2'b00, modulus}) + XW'(1);
        fold_x = sum_x;
        if (circ_en) begin
            if (sum_x > top_x) begin
                fold_x = sum_x - size_x;
            end else if (sum_x < base_x) begin
                fold_x = sum_x + size_x;
            end
        end
        next = fold_x[W-1:0];
    end
endmodule

// File: rtl/mod_addr_unit.sv
module mod_addr_unit
    import mod_addr_pkg::*;
#(
    parameter int SEL_W        = 2,
    parameter int NUM_CIRC_PTR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     ptr_in,
    input  logic [SEL_W-1:0]  ptr_sel,
    input  logic [1:0]        mode,
    input  logic [AW-1:0]     offset,
    input  logic [AW-1:0]     modulus,
    output logic [AW-1:0]     ea_out,
    output logic [AW-1:0]     ptr_out
);
    localparam logic [AW-1:0] LINEAR_CODE = '1;

    upd_mode_e           mode_e;
    logic [AW-1:0]       blk_mask;
    logic signed [AW+1:0] step;
    logic                circ_en;
    logic [AW-1:0]       next_ptr;
    addr_state_t         st_d;
    addr_state_t         st_q;

    assign mode_e  = upd_mode_e'(mode);
    assign circ_en = (int'(ptr_sel) < NUM_CIRC_PTR) && (modulus != LINEAR_CODE);

    mod_mask_gen #(.W(AW)) u_mask (
        .modulus (modulus),
        .mask    (blk_mask)
    );

    mod_step_gen #(.W(AW)) u_step (
        .mode    (mode_e),
        .offset  (offset),
        .step    (step)
    );

    mod_wrap_unit #(.W(AW)) u_wrap (
        .ptr     (ptr_in),
        .step    (step),
        .modulus (modulus),
        .mask    (blk_mask),
        .circ_en (circ_en),
        .next    (next_ptr)
    );

    always_comb begin
        st_d.ea  = ptr_in;
        st_d.ptr = (mode_e == UPD_HOLD) ? ptr_in : next_ptr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ea_out  = st_q.ea;
    assign ptr_out = st_q.ptr;
endmodule

// File: rtl/mod_addr_unit_chk.sv
module mod_addr_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] ptr_in,
    input logic [1:0]  ptr_sel,
    input logic [1:0]  mode,
    input logic [15:0] modulus,
    input logic [15:0] ea_out,
    input logic [15:0] ptr_out
);
    function automatic logic [15:0] smear(input logic [15:0] v);
        logic [15:0] r;
        r = '0;
        for (int i = 15; i >= 0; i--) begin
            r[i] = (i == 15) ? v[i] : (v[i] | r[i+1]);
        end
        return r;
    endfunction

    logic circ_now;
    assign circ_now = (ptr_sel < 2'd2) && (modulus != 16'hFFFF);

    AST_EA_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ea_out == $past(ptr_in)); // R1

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'd0 |=> ptr_out == $past(ptr_in)); // R2

    AST_HIGH_SEL_LINEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_sel >= 2'd2 && mode == 2'd1) |=> ptr_out == 16'($past(ptr_in) + 16'd1)); // R3

    AST_FULL_MOD_LINEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (modulus == 16'hFFFF && mode == 2'd2) |=> ptr_out == 16'($past(ptr_in) - 16'd1)); // R4

    AST_DEC_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (circ_now && mode == 2'd2 && (ptr_in & smear(modulus)) == 16'd0)
        |=> ptr_out == 16'($past(ptr_in) + $past(modulus))); // R7
endmodule

bind mod_addr_unit mod_addr_unit_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ptr_in  (ptr_in),
    .ptr_sel (ptr_sel),
    .mode    (mode),
    .modulus (modulus),
    .ea_out  (ea_out),
    .ptr_out (ptr_out)
);

// File: tb/sim_mod_addr_unit.sv
module sim_mod_addr_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ptr_in = '0;
    logic [1:0]  ptr_sel = '0;
    logic [1:0]  mode = '0;
    logic [15:0] offset = '0;
    logic [15:0] modulus = 16'hFFFF;
    logic [15:0] ea_out;
    logic [15:0] ptr_out;

    int n_checks = 0;
    int n_errors = 0;

    bit    pend = 0;
    bit    pend_gap = 0;
    int    exp_ea;
    int    exp_ptr;
    string pend_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    mod_addr_unit u0 (
        .clk(clk), .rst_n(rst_n), .ptr_in(ptr_in), .ptr_sel(ptr_sel),
        .mode(mode), .offset(offset), .modulus(modulus),
        .ea_out(ea_out), .ptr_out(ptr_out)
    );

    function automatic int ref_next(int p, int sel, int md, int ofs, int mv);
        int d, sz, blk, lo, hi, s;
        if (md == 0) return p;
        d = (md == 1) ? 1 : (md == 2) ? -1 : ((ofs >= 32768) ? ofs - 65536 : ofs);
        if (sel >= 2 || mv == 65535) return (p + d) & 16'hFFFF;
        sz = mv + 1;
        blk = 1;
        while (blk < sz) blk = blk * 2;
        lo = p - (p % blk);
        hi = lo + sz - 1;
        s = p + d;
        if (s > hi) s = s - sz;
        else if (s < lo) s = s + sz;
        return s & 16'hFFFF;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic settle_pending();
        if (pend) begin
            check("R1", {pend_tag, " ea"}, int'(ea_out), exp_ea);
            check(pend_tag, "ptr", int'(ptr_out), exp_ptr);
            if (pend_gap) begin
                n_checks++;
                if (ptr_out >= 16'h00A5 && ptr_out <= 16'h00BF) begin
                    n_errors++;
                    $display("FAIL R9 gap reached: actual=%h expected outside 00A5..00BF", ptr_out);
                end
            end
        end
        pend = 0;
    endtask

    // Drive one update at a falling edge; results are due at the next falling edge.
    task automatic op(int p, int sel, int md, int ofs, int mv, string tag, bit gap, output int nxt);
        @(negedge clk);
        settle_pending();
        ptr_in  = 16'(p);
        ptr_sel = 2'(sel);
        mode    = 2'(md);
        offset  = 16'(ofs);
        modulus = 16'(mv);
        exp_ea  = p & 16'hFFFF;
        exp_ptr = ref_next(p, sel, md, ofs, mv);
        pend_tag = tag;
        pend_gap = gap;
        pend = 1;
        nxt = exp_ptr;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        int p, r;
        ptr_in = 16'h1234;
        mode = 2'd1;
        repeat (3) @(negedge clk);
        check("R10", "ea in reset", int'(ea_out), 0);
        check("R10", "ptr in reset", int'(ptr_out), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: hold mode reaches the gap address
        op(16'h00A7, 0, 0, 0, 36, "R2", 0, r);
        // R3: high selects stay linear even with a circular modulus
        op(16'h00A4, 2, 1, 0, 36, "R3", 0, r);
        op(16'h0000, 3, 2, 0, 36, "R3", 0, r);
        op(16'hFFF0, 2, 3, 16'h0020, 7, "R3", 0, r);
        // R4: all-ones modulus is linear for low selects
        op(16'hFFFF, 0, 1, 0, 16'hFFFF, "R4", 0, r);
        op(16'h0080, 1, 2, 0, 16'hFFFF, "R4", 0, r);
        // R5: base derived from pointer bits (size 16 at 0x1230)
        op(16'h123F, 0, 1, 0, 15, "R5", 0, r);
        op(16'h1230, 1, 2, 0, 15, "R5", 0, r);
        // R6/R9: walk upward through a 37-entry buffer
        p = 16'h0080;
        for (int i = 0; i < 80; i++) op(p, 0, 1, 0, 36, "R6", 1, p);
        // R7/R9: walk downward
        p = 16'h0080;
        for (int i = 0; i < 80; i++) op(p, 1, 2, 0, 36, "R7", 1, p);
        // R8: offset wraps both ways, including a full-size step
        op(16'h00A0, 0, 3, 10, 36, "R8", 1, r);
        op(16'h0082, 0, 3, 16'(-5), 36, "R8", 1, r);
        op(16'h0090, 1, 3, 37, 36, "R8", 1, r);
        op(16'h0090, 1, 3, 16'(-37), 36, "R8", 1, r);
        p = 16'h0080;
        for (int i = 0; i < 60; i++) op(p, i % 2, 3, 7, 36, "R9", 1, p);
        // R8: random circular and linear mix, alternating selects
        for (int i = 0; i < 400; i++) begin
            int sz, blk, base, pp, ofs, sel, md;
            sz = 1 + int'($urandom_range(0, 999));
            blk = 1;
            while (blk < sz) blk = blk * 2;
            base = (int'($urandom_range(0, 65535)) / blk) * blk;
            if (base + blk > 65536) base = 0;
            pp = base + int'($urandom_range(0, sz - 1));
            ofs = int'($urandom_range(0, 2 * sz)) - sz;
            sel = i % 4;
            md = int'($urandom_range(0, 3));
            op(pp, sel, md, ofs & 16'hFFFF, sz - 1, "R8", 0, r);
        end
        @(negedge clk);
        settle_pending();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule